// File: doc/BRIEF.md
# Processor Trace Nibble Packetizer

This block takes one trace event per retired or flow-changing instruction from a processor core and turns it into a stream of 4-bit codes, one code per clock. An event carries a completion flag, an optional data operand (read or write, 1, 2 or 4 bytes) and an optional branch target address. Each event becomes a record: a status code for the completed instruction, then an optional address section and an optional operand section. Each section starts with a size marker nibble, so the payload describes its own length.

Three configuration inputs set what is shown. One enables operands of read references, one enables operands of write references, and a 2-bit field picks how many bytes of the branch target go out. Events wait in a short queue. When the queue is full the core sees `ev_ready` low and holds its event, so no event is lost. A record is built from the configuration present when its event leaves the queue, so a change never splits a payload.

Top module: `trc_nibble_packer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after, `trace_nib` is 0 and `ev_ready` is 1.
- R2: When no record is being emitted, `trace_nib` shows the idle code 0.
- R3: An event with `ev_done` set emits status code 1 as the first nibble of its record. An event with `ev_done` clear emits no status nibble.
- R4: A shown operand emits a marker and then its bytes. `ev_dsize` 00 gives marker 0x8 and 1 byte. 01 gives marker 0x9 and 2 bytes. 10 or 11 gives marker 0xB and 4 bytes. Bytes go out from the lowest-order byte upward, and within each byte the low nibble goes first.
- R5: A read operand (`ev_dwr`=0) is shown only if `cfg_rd_en`=1. A write operand (`ev_dwr`=1) is shown only if `cfg_wr_en`=1. A hidden operand emits neither marker nor data.
- R6: A target address (`ev_tvld`=1) is shown according to `cfg_tsel`. 00 hides it. 01 gives marker 0x9 and 2 bytes. 10 gives marker 0xA and 3 bytes. 11 gives marker 0xB and 4 bytes. The nibble order is the same as in R4.
- R7: When an event shows both a target and an operand, the order is status, target marker, target bytes, operand marker, operand bytes.
- R8: Up to Q_DEPTH (default 4) events are queued. `ev_ready` is low exactly while the queue is full. An event is accepted when `ev_valid` and `ev_ready` are both high at a clock edge, and every accepted event is emitted.
- R9: The configuration inputs are sampled only when an event leaves the queue to start its record. A change during a record does not affect that record.
- R10: Records of queued events follow each other with no idle nibble between them. An event accepted into an empty, idle block puts its first nibble on `trace_nib` at the second clock edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | Event offered by the core |
| ev_ready | output | 1 | Queue has room; event accepted this edge if valid |
| ev_done | input | 1 | Instruction completed |
| ev_dvld | input | 1 | Event carries a data operand |
| ev_dwr | input | 1 | Operand is a write (1) or a read (0) |
| ev_dsize | input | 2 | Operand size: 00 byte, 01 two bytes, 10/11 four bytes |
| ev_data | input | 32 | Operand value |
| ev_tvld | input | 1 | Event carries a branch target |
| ev_taddr | input | 32 | Branch target address |
| cfg_rd_en | input | 1 | Show read operands |
| cfg_wr_en | input | 1 | Show write operands |
| cfg_tsel | input | 2 | Target bytes shown: 00 none, 01 two, 10 three, 11 four |
| trace_nib | output | 4 | Trace nibble stream |

## Verification
The stimulus covers status-only events, read operands of every size code, and write/read operands under each of the four direction-enable settings. Together these separate marker choice from operand filtering. Every target-width code is applied with distinct nibble values in every byte, so a reversed byte or nibble order or a wrong width shows up as a mismatch. Long back-to-back bursts fill the queue, which tests the stall and the gap-free chaining between records. Configuration changes made while a queued burst drains show whether the settings are taken at the record boundary or in the middle of a payload.

// File: rtl/trc_pkg.sv
// Shared widths, nibble codes and the event record for the trace packetizer.
// Assumes 32-bit operands and addresses; record lengths derive from them.
package trc_pkg;
    localparam int TRC_DATA_W  = 32;
    localparam int TRC_ADDR_W  = 32;
    localparam int TRC_D_NIB   = TRC_DATA_W / 4;
    localparam int TRC_A_NIB   = TRC_ADDR_W / 4;
    // status + two markers + both payloads
    localparam int TRC_MAX_NIB = 3 + TRC_D_NIB + TRC_A_NIB;
    localparam int TRC_SEQ_W   = 4 * TRC_MAX_NIB;
    localparam int TRC_LEN_W   = $clog2(TRC_MAX_NIB + 1);

    localparam logic [3:0] NIB_IDLE = 4'h0;
    localparam logic [3:0] NIB_DONE = 4'h1;
    localparam logic [3:0] MRK_1B   = 4'h8;
    localparam logic [3:0] MRK_2B   = 4'h9;
    localparam logic [3:0] MRK_3B   = 4'hA;
    localparam logic [3:0] MRK_4B   = 4'hB;

    typedef enum logic [1:0] {
        OPSZ_BYTE = 2'b00,
        OPSZ_HALF = 2'b01,
        OPSZ_WORD = 2'b10,
        OPSZ_WRD2 = 2'b11
    } opsz_e;

    typedef enum logic [1:0] {
        TSEL_NONE = 2'b00,
        TSEL_2B   = 2'b01,
        TSEL_3B   = 2'b10,
        TSEL_4B   = 2'b11
    } tsel_e;

    typedef struct packed {
        logic                  done;
        logic                  dvld;
        logic                  dwr;
        logic [1:0]            dsize;
        logic [TRC_DATA_W-1:0] data;
        logic                  tvld;
        logic [TRC_ADDR_W-1:0] taddr;
    } trc_evt_t;

    localparam int TRC_EVT_W = $bits(trc_evt_t);
endpackage

// File: rtl/trc_evq.sv
// Event queue: a synchronous FIFO of DEPTH entries holding W-bit words.
// Assumes the caller never pushes while full or pops while empty; both are
// also gated internally. Storage carries no reset; control state does.
module trc_evq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Write the incoming word into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers with wrap and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/trc_rec_plan.sv
// Record planner: from one event and the live configuration, builds the full
// nibble sequence of its record (first nibble in the low bits) and its length.
// Purely combinational; the serializer captures it at the record boundary.
module trc_rec_plan
    import trc_pkg::*;
(
    input  trc_evt_t               evt,
    input  logic                   cfg_rd_en,
    input  logic                   cfg_wr_en,
    input  logic [1:0]             cfg_tsel,
    output logic [TRC_SEQ_W-1:0]   seq,
    output logic [TRC_LEN_W-1:0]   len
);
    logic       show_t, show_d;
    logic [3:0] t_mark, d_mark;
    int         t_n, d_n;

    // Decode target width and marker from the select field.
    always_comb begin
        case (tsel_e'(cfg_tsel))
            TSEL_2B: begin t_n = 4; t_mark = MRK_2B; end
            TSEL_3B: begin t_n = 6; t_mark = MRK_3B; end
            TSEL_4B: begin t_n = 8; t_mark = MRK_4B; end
            default: begin t_n = 0; t_mark = NIB_IDLE; end
        endcase
        show_t = evt.tvld && (cfg_tsel != TSEL_NONE);
    end

    // Decode operand width, marker and direction filter.
    always_comb begin
        case (opsz_e'(evt.dsize))
            OPSZ_BYTE: begin d_n = 2; d_mark = MRK_1B; end
            OPSZ_HALF: begin d_n = 4; d_mark = MRK_2B; end
            default:   begin d_n = 8; d_mark = MRK_4B; end
        endcase
        show_d = evt.dvld && (evt.dwr ? cfg_wr_en : cfg_rd_en);
    end

    // Lay out status, target section and operand section in emission order.
    always_comb begin
        int pos;
        seq = '0;
        pos = 0;
        if (evt.done) begin
            seq[pos*4 +: 4] = NIB_DONE;
            pos = pos + 1;
        end
        if (show_t) begin
            seq[pos*4 +: 4] = t_mark;
            pos = pos + 1;
            for (int k = 0; k < TRC_A_NIB; k++) begin
                if (k < t_n) seq[(pos+k)*4 +: 4] = evt.taddr[k*4 +: 4];
            end
            pos = pos + t_n;
        end
        if (show_d) begin
            seq[pos*4 +: 4] = d_mark;
            pos = pos + 1;
            for (int k = 0; k < TRC_D_NIB; k++) begin
                if (k < d_n) seq[(pos+k)*4 +: 4] = evt.data[k*4 +: 4];
            end
            pos = pos + d_n;
        end
        len = TRC_LEN_W'(pos);
    end
endmodule

// File: rtl/trc_nib_ser.sv
// Nibble serializer: shifts out one captured record, one nibble per clock,
// and loads the next record in the same cycle its last nibble leaves, so
// queued records chain with no gap. Shows the idle code when empty.
module trc_nib_ser
    import trc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_empty,
    input  logic [TRC_SEQ_W-1:0] plan_seq,
    input  logic [TRC_LEN_W-1:0] plan_len,
    output logic                 pop,
    output logic [TRC_LEN_W-1:0] cnt,
    output logic [3:0]           trace_nib
);
    logic [TRC_SEQ_W-1:0] sh;

    // Take the next event at a record boundary: idle or on the last nibble.
    assign pop = (cnt <= TRC_LEN_W'(1)) && !q_empty;

    // Emit the current nibble, then shift or reload the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            cnt       <= '0;
            trace_nib <= NIB_IDLE;
        end else begin
            trace_nib <= (cnt != '0) ? sh[3:0] : NIB_IDLE;
            if (pop) begin
                sh  <= plan_seq;
                cnt <= plan_len;
            end else if (cnt != '0) begin
                sh  <= sh >> 4;
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/trc_nibble_packer.sv
// Top of the trace packetizer: queues core events, plans each record from
// the configuration at dequeue time, and serializes it onto a 4-bit stream.
// Assumes the core holds an event stable until ev_ready accepts it.
module trc_nibble_packer
    import trc_pkg::*;
#(
    parameter int Q_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    output logic                  ev_ready,
    input  logic                  ev_done,
    input  logic                  ev_dvld,
    input  logic                  ev_dwr,
    input  logic [1:0]            ev_dsize,
    input  logic [TRC_DATA_W-1:0] ev_data,
    input  logic                  ev_tvld,
    input  logic [TRC_ADDR_W-1:0] ev_taddr,
    input  logic                  cfg_rd_en,
    input  logic                  cfg_wr_en,
    input  logic [1:0]            cfg_tsel,
    output logic [3:0]            trace_nib
);
    localparam int QCW = $clog2(Q_DEPTH + 1);

    trc_evt_t             in_evt, head_evt;
    logic [TRC_EVT_W-1:0] head_raw;
    logic [QCW-1:0]       q_count;
    logic                 q_full, q_empty, q_pop;
    logic [TRC_SEQ_W-1:0] plan_seq;
    logic [TRC_LEN_W-1:0] plan_len, ser_cnt;

    // Gather the core's event fields into one record.
    always_comb begin
        in_evt.done  = ev_done;
        in_evt.dvld  = ev_dvld;
        in_evt.dwr   = ev_dwr;
        in_evt.dsize = ev_dsize;
        in_evt.data  = ev_data;
        in_evt.tvld  = ev_tvld;
        in_evt.taddr = ev_taddr;
    end

    assign ev_ready = !q_full;
    assign head_evt = trc_evt_t'(head_raw);

    trc_evq #(.DEPTH(Q_DEPTH), .W(TRC_EVT_W)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ev_valid && ev_ready),
        .din   (in_evt),
        .pop   (q_pop),
        .dout  (head_raw),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    trc_rec_plan u_plan (
        .evt       (head_evt),
        .cfg_rd_en (cfg_rd_en),
        .cfg_wr_en (cfg_wr_en),
        .cfg_tsel  (cfg_tsel),
        .seq       (plan_seq),
        .len       (plan_len)
    );

    trc_nib_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_empty   (q_empty),
        .plan_seq  (plan_seq),
        .plan_len  (plan_len),
        .pop       (q_pop),
        .cnt       (ser_cnt),
        .trace_nib (trace_nib)
    );
endmodule

// File: rtl/trc_nibble_packer_chk.sv
// Property checker for the trace packetizer, bound onto every instance.
// Watches the queue occupancy, the dequeue strobe and the serializer count.
module trc_nibble_packer_chk
    import trc_pkg::*;
#(
    parameter int Q_DEPTH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ev_ready,
    input logic [3:0]                   trace_nib,
    input logic [$clog2(Q_DEPTH+1)-1:0] q_count,
    input logic                         q_pop,
    input logic [TRC_LEN_W-1:0]         ser_cnt
);
    localparam int QCW = $clog2(Q_DEPTH + 1);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (trace_nib == NIB_IDLE && ev_ready));

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_cnt == '0) |=> (trace_nib == NIB_IDLE));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCW'(Q_DEPTH));

    assert_full_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == QCW'(Q_DEPTH)) |-> !ev_ready);

    assert_pop_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (ser_cnt <= TRC_LEN_W'(1)));
endmodule

bind trc_nibble_packer trc_nibble_packer_chk #(.Q_DEPTH(Q_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_ready  (ev_ready),
    .trace_nib (trace_nib),
    .q_count   (q_count),
    .q_pop     (q_pop),
    .ser_cnt   (ser_cnt)
);

// File: tb/trc_nibble_packer_tb.sv
// Bench: behavioural reference (event queue + expected nibble queue),
// stepped on every rising edge and compared at every falling edge.
module trc_nibble_packer_tb;
    import trc_pkg::*;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0, ev_done = 1'b0, ev_dvld = 1'b0, ev_dwr = 1'b0, ev_tvld = 1'b0;
    logic [1:0]  ev_dsize = 2'b00;
    logic [31:0] ev_data = '0, ev_taddr = '0;
    logic        cfg_rd_en = 1'b1, cfg_wr_en = 1'b1;
    logic [1:0]  cfg_tsel = 2'b11;
    logic        ev_ready;
    logic [3:0]  trace_nib;

    int    n_checks = 0, n_fail = 0, cycles = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    trc_evt_t mq[$];
    int       cur[$];
    int       m_out = 0;

    always #10 clk = ~clk;

    trc_nibble_packer #(.Q_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_done(ev_done), .ev_dvld(ev_dvld), .ev_dwr(ev_dwr), .ev_dsize(ev_dsize),
        .ev_data(ev_data), .ev_tvld(ev_tvld), .ev_taddr(ev_taddr),
        .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .cfg_tsel(cfg_tsel),
        .trace_nib(trace_nib)
    );

    // Expected nibbles of one record, straight from R3..R7.
    function automatic void load_rec(trc_evt_t e, logic rd, logic wr, logic [1:0] ts);
        int nb;
        if (e.done) cur.push_back(1);
        if (e.tvld && ts != 2'b00) begin
            nb = (ts == 2'b01) ? 2 : (ts == 2'b10) ? 3 : 4;
            cur.push_back(nb == 2 ? 9 : nb == 3 ? 10 : 11);
            for (int b = 0; b < nb; b++) begin
                cur.push_back(int'(e.taddr[b*8 +: 4]));
                cur.push_back(int'(e.taddr[b*8+4 +: 4]));
            end
        end
        if (e.dvld && (e.dwr ? wr : rd)) begin
            nb = (e.dsize == 2'b00) ? 1 : (e.dsize == 2'b01) ? 2 : 4;
            cur.push_back(nb == 1 ? 8 : nb == 2 ? 9 : 11);
            for (int b = 0; b < nb; b++) begin
                cur.push_back(int'(e.data[b*8 +: 4]));
                cur.push_back(int'(e.data[b*8+4 +: 4]));
            end
        end
    endfunction

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); cur.delete(); m_out = 0;
        end else begin
            int  qsz;
            bit  take;
            trc_evt_t ne, he;
            qsz  = mq.size();
            take = (cur.size() <= 1) && (qsz > 0);
            m_out = (cur.size() > 0) ? cur[0] : 0;
            if (cur.size() > 0) void'(cur.pop_front());
            if (take) begin
                he = mq.pop_front();
                load_rec(he, cfg_rd_en, cfg_wr_en, cfg_tsel);
            end
            if (ev_valid && qsz < DEPTH) begin
                ne.done = ev_done; ne.dvld = ev_dvld; ne.dwr = ev_dwr; ne.dsize = ev_dsize;
                ne.data = ev_data; ne.tvld = ev_tvld; ne.taddr = ev_taddr;
                mq.push_back(ne);
            end
        end
    end

    task automatic check(bit ok, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                check(trace_nib == 4'h0, "reset trace_nib", int'(trace_nib), 0);
                check(ev_ready == 1'b1, "reset ev_ready", int'(ev_ready), 1);
            end else begin
                check(int'(trace_nib) == m_out, "trace_nib", int'(trace_nib), m_out);
                check(ev_ready == (mq.size() < DEPTH), "ev_ready",
                      int'(ev_ready), int'(mq.size() < DEPTH));
            end
        end
    end

    // Offer one event and hold it until accepted; call at a falling edge.
    task automatic send(bit d, bit dv, bit wr, logic [1:0] sz, logic [31:0] dat,
                        bit tv, logic [31:0] ta);
        ev_valid = 1'b1; ev_done = d; ev_dvld = dv; ev_dwr = wr; ev_dsize = sz;
        ev_data = dat; ev_tvld = tv; ev_taddr = ta;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic drain();
        while (mq.size() != 0 || cur.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hang counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset values
        cur_req = "R1";
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R2: idle stream
        cur_req = "R2";
        repeat (6) @(negedge clk);
        // R3: status only, and an event with nothing to show
        cur_req = "R3";
        send(1, 0, 0, 2'b00, 32'h0, 0, 32'h0);
        send(0, 0, 0, 2'b00, 32'h0, 0, 32'h0);
        send(1, 0, 0, 2'b00, 32'h0, 0, 32'h0);
        drain();
        // R4: operand sizes and nibble order
        cur_req = "R4";
        for (int s = 0; s < 4; s++) begin
            send(1, 1, 0, 2'(s), 32'hC3B2A190 + 32'(s), 0, 32'h0);
            drain();
        end
        // R5: direction filter under all enable settings
        cur_req = "R5";
        for (int c = 0; c < 4; c++) begin
            cfg_rd_en = c[0]; cfg_wr_en = c[1];
            send(1, 1, 1, 2'b01, 32'h00005E7D, 0, 32'h0);
            send(1, 1, 0, 2'b00, 32'h000000F6, 0, 32'h0);
            drain();
        end
        cfg_rd_en = 1'b1; cfg_wr_en = 1'b1;
        // R6: every target width code
        cur_req = "R6";
        for (int t = 0; t < 4; t++) begin
            cfg_tsel = 2'(t);
            send(1, 0, 0, 2'b00, 32'h0, 1, 32'h76543210 ^ 32'(t * 32'h11111111));
            drain();
        end
        // R7: target before operand
        cur_req = "R7";
        cfg_tsel = 2'b10;
        send(1, 1, 1, 2'b10, 32'hDEADBEEF, 1, 32'h0ACE5B21);
        send(0, 1, 0, 2'b01, 32'h00009A8B, 1, 32'hFEDCBA98);
        drain();
        // R8: burst that fills the queue
        cur_req = "R8";
        cfg_tsel = 2'b11;
        for (int i = 0; i < 10; i++)
            send(1, 1, i[0], 2'b10, 32'h13579BDF + 32'(i), 1, 32'h2468ACE0 - 32'(i));
        drain();
        // R9: configuration changes while a queued burst drains
        cur_req = "R9";
        for (int i = 0; i < 3; i++)
            send(1, 1, 0, 2'b10, 32'hA5A55A5A + 32'(i), 1, 32'h11223344 + 32'(i));
        repeat (5) @(negedge clk);
        cfg_tsel = 2'b01; cfg_rd_en = 1'b0;
        repeat (9) @(negedge clk);
        cfg_tsel = 2'b10; cfg_rd_en = 1'b1;
        drain();
        // R10: gap-free chaining and first-nibble latency
        cur_req = "R10";
        for (int i = 0; i < 8; i++) send(1, 0, 0, 2'b00, 32'h0, 0, 32'h0);
        drain();
        send(1, 1, 0, 2'b00, 32'h0000004C, 0, 32'h0);
        drain();
        finish_run();
    end
endmodule